// File: doc/BRIEF.md
# External Request Internal Decoder

This block sits behind a processor's system bus port and answers requests that an outside agent aims at the processor's own resources. A request carries a valid strobe, a read/write flag, a 64-bit address and 64 bits of write data. A three-bit field at address bits 6:4 picks one of eight internal slots. Only slot 0, the interrupt register, accepts writes. The block holds that register and drives its bits out as interrupt request lines.

There are no readable internal resources. Each read request gets a one-cycle registered response. Its data is forced to zero, and its data identifier has the erroneous-data flag (identifier bit 5) set. A separate error output mirrors that flag. Writes to any other slot are dropped and leave all state untouched.

Top module: `xreq_decoder`

## Requirements
- R1: While reset is high and on the first cycle after it, irq_out is all zeros and rsp_vld, rsp_err and rsp_id are zero.
- R2: A request with req_vld=1, req_wr=1 and address bits 6:4 equal to 3'b000 loads req_wdata[IRQ_W-1:0] into the interrupt register, and irq_out shows the new value after the next rising clock edge.
- R3: A write whose address bits 6:4 are any value other than 3'b000 leaves irq_out unchanged.
- R4: Only address bits 6:4 take part in target selection. Every other address bit has no effect on whether a write lands.
- R5: Each read request (req_vld=1, req_wr=0) yields rsp_vld=1 on exactly the next cycle. rsp_vld is 0 in every cycle that does not follow a read request.
- R6: rsp_data is all zeros whenever rsp_vld is 1.
- R7: When rsp_vld is 1, rsp_id has only bit 5 set (the erroneous-data flag) and rsp_err is 1. When rsp_vld is 0, rsp_id is zero and rsp_err is 0.
- R8: Read requests never change irq_out, whatever the address.
- R9: Inputs with req_vld=0 change neither irq_out nor the response outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_vld | input | 1 | Request strobe |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | 64 | Request address; bits 6:4 select the target |
| req_wdata | input | 64 | Write data |
| irq_out | output | 8 | Interrupt register contents |
| rsp_vld | output | 1 | Read response valid |
| rsp_data | output | 64 | Read response data (always zero) |
| rsp_id | output | 9 | Response data identifier; bit 5 flags erroneous data |
| rsp_err | output | 1 | Erroneous-data flag of the response |

## Verification
The hardest case to reach from the ports is a write that differs from a landing write in nothing but the selector field. Examples are the same data and the same upper address bits with bits 6:4 nonzero, or a write with bits 6:4 at zero but the neighbouring bits 3:0 and 7 set. Random address draws seldom produce these near misses together with data that differs from the current register value. The stimulus therefore forces the selector field on a share of random writes and fills the remaining address bits at random. It also adds directed writes that change only one selector bit, each carrying a value different from the register's current contents.

// File: rtl/xreq_pkg.sv
package xreq_pkg;
  localparam int unsigned BUS_W   = 64;
  localparam int unsigned SEL_LO  = 4;
  localparam int unsigned SEL_W   = 3;
  localparam int unsigned CMD_W   = 9;
  localparam int unsigned ERR_BIT = 5;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } xreq_op_e;

  function automatic xreq_op_e classify(input logic vld, input logic wr);
    if (!vld)   return OP_IDLE;
    else if (wr) return OP_WRITE;
    else        return OP_READ;
  endfunction
endpackage

// File: rtl/xreq_sel_decode.sv
module xreq_sel_decode #(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned SEL_LO = 4,
  parameter int unsigned SEL_W  = 3,
  localparam int unsigned N_TGT = 1 << SEL_W
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  output logic [N_TGT-1:0]  tgt_wr
);
  logic [SEL_W-1:0] sel;
  assign sel = addr[SEL_LO +: SEL_W];

  for (genvar t = 0; t < N_TGT; t++) begin : g_tgt
    assign tgt_wr[t] = wr_en && (sel == SEL_W'(t));
  end

  always_comb begin
    // R4 at most one slot is ever selected
    sel_onehot_chk: assert ($onehot0(tgt_wr));
  end
endmodule

// File: rtl/xreq_irq_reg.sv
module xreq_irq_reg #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned IRQ_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld,
  input  logic [DATA_W-1:0] wdata,
  output logic [IRQ_W-1:0]  irq_q
);
  always_ff @(posedge clk) begin
    if (rst)     irq_q <= '0;
    else if (ld) irq_q <= wdata[IRQ_W-1:0];
  end

  // R2
  irq_load_chk: assert property (@(posedge clk) disable iff (rst)
    ld |=> irq_q == $past(wdata[IRQ_W-1:0]));
  // R3
  irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ld |=> $stable(irq_q));
endmodule

// File: rtl/xreq_rd_resp.sv
module xreq_rd_resp #(
  parameter int unsigned DATA_W  = 64,
  parameter int unsigned CMD_W   = 9,
  parameter int unsigned ERR_BIT = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd,
  output logic              rsp_vld,
  output logic [DATA_W-1:0] rsp_data,
  output logic [CMD_W-1:0]  rsp_id,
  output logic              rsp_err
);
  localparam logic [CMD_W-1:0] ERR_ID = CMD_W'(1) << ERR_BIT;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_vld  <= 1'b0;
      rsp_data <= '0;
      rsp_id   <= '0;
      rsp_err  <= 1'b0;
    end else begin
      rsp_vld  <= rd;
      rsp_data <= '0;
      rsp_id   <= rd ? ERR_ID : '0;
      rsp_err  <= rd;
    end
  end

  // R5
  rsp_follow_chk: assert property (@(posedge clk) disable iff (rst)
    rd |=> rsp_vld);
  // R5
  rsp_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !rd |=> !rsp_vld);
  // R6
  rsp_zero_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_vld |-> rsp_data == '0);
  // R7
  rsp_errflag_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_vld |-> (rsp_err && $countones(rsp_id) == 1 && rsp_id[ERR_BIT]));
endmodule

// File: rtl/xreq_decoder.sv
module xreq_decoder
  import xreq_pkg::*;
#(
  parameter int unsigned IRQ_W    = 8,
  parameter int unsigned IRQ_SLOT = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_vld,
  input  logic             req_wr,
  input  logic [BUS_W-1:0] req_addr,
  input  logic [BUS_W-1:0] req_wdata,
  output logic [IRQ_W-1:0] irq_out,
  output logic             rsp_vld,
  output logic [BUS_W-1:0] rsp_data,
  output logic [CMD_W-1:0] rsp_id,
  output logic             rsp_err
);
  localparam int unsigned N_TGT = 1 << SEL_W;

  xreq_op_e         op;
  logic [N_TGT-1:0] tgt_wr;

  assign op = classify(req_vld, req_wr);

  xreq_sel_decode #(.ADDR_W(BUS_W), .SEL_LO(SEL_LO), .SEL_W(SEL_W)) u_dec (
    .addr   (req_addr),
    .wr_en  (op == OP_WRITE),
    .tgt_wr (tgt_wr)
  );

  xreq_irq_reg #(.DATA_W(BUS_W), .IRQ_W(IRQ_W)) u_irq (
    .clk   (clk),
    .rst   (rst),
    .ld    (tgt_wr[IRQ_SLOT]),
    .wdata (req_wdata),
    .irq_q (irq_out)
  );

  xreq_rd_resp #(.DATA_W(BUS_W), .CMD_W(CMD_W), .ERR_BIT(ERR_BIT)) u_rsp (
    .clk      (clk),
    .rst      (rst),
    .rd       (op == OP_READ),
    .rsp_vld  (rsp_vld),
    .rsp_data (rsp_data),
    .rsp_id   (rsp_id),
    .rsp_err  (rsp_err)
  );

  // R8
  rd_no_irq_chk: assert property (@(posedge clk) disable iff (rst)
    (req_vld && !req_wr) |=> $stable(irq_out));
  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !req_vld |=> ($stable(irq_out) && !rsp_vld));
endmodule

// File: tb/sim_xreq_decoder.sv
module sim_xreq_decoder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_vld = 1'b0, req_wr = 1'b0;
  logic [63:0] req_addr = '0, req_wdata = '0;
  logic [7:0]  irq_out;
  logic        rsp_vld, rsp_err;
  logic [63:0] rsp_data;
  logic [8:0]  rsp_id;

  int total = 0, bad = 0;
  bit done = 0;
  logic [7:0] m_irq = '0;

  always #2.5 clk = ~clk;

  xreq_decoder u0 (.*);

  function automatic logic lands(input logic v, input logic w, input logic [63:0] a);
    return v && w && (a[6:4] == 3'b000);
  endfunction

  function automatic logic [8:0] exp_id(input logic rd);
    return rd ? 9'h020 : 9'h000;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic w, input logic [63:0] a, input logic [63:0] d);
    logic rd;
    @(negedge clk);
    req_vld = v; req_wr = w; req_addr = a; req_wdata = d;
    rd = v && !w;
    if (lands(v, w, a)) m_irq = d[7:0];
    @(posedge clk); #1;
    // R2 R3 R4 R8 R9: register tracks model
    chk(irq_out == m_irq, "R2/R3/R8", 64'(irq_out), 64'(m_irq));
    // R5 R9
    chk(rsp_vld == rd, "R5", 64'(rsp_vld), 64'(rd));
    // R7
    chk(rsp_id == exp_id(rd) && rsp_err == rd, "R7", {rsp_err, 55'd0, rsp_id}, {rd, 55'd0, exp_id(rd)});
    // R6
    if (rsp_vld) chk(rsp_data == '0, "R6", rsp_data, 64'd0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1;
    // R1 during reset
    chk(irq_out == 0 && !rsp_vld && !rsp_err && rsp_id == 0, "R1", {rsp_vld, 55'd0, irq_out}, 64'd0);
    req_vld = 1'b1; req_wr = 1'b0;
    @(negedge clk); rst = 1'b0; req_vld = 1'b0;
    @(posedge clk); #1;
    // R1 first cycle after reset
    chk(irq_out == 0 && !rsp_vld && rsp_id == 0, "R1", {rsp_vld, 55'd0, irq_out}, 64'd0);

    // directed
    step(1, 1, 64'hFFFF_FFFF_FFFF_FF8F, 64'h1234_5678_9ABC_DEA5); // R4 sel0, other bits set
    chk(irq_out == 8'hA5, "R2", 64'(irq_out), 64'hA5);
    step(1, 1, 64'h0000_0000_0000_0010, 64'h3C);              // R3 sel=1
    chk(irq_out == 8'hA5, "R3", 64'(irq_out), 64'hA5);
    step(1, 1, 64'h0000_0000_0000_0070, 64'hFF);              // R3 sel=7
    step(1, 1, 64'h0000_0000_0000_0040, 64'h11);              // R3 sel=4
    step(0, 1, 64'h0, 64'h77);                                // R9 idle write-looking
    chk(irq_out == 8'hA5, "R9", 64'(irq_out), 64'hA5);
    step(1, 0, 64'h0, 64'h5A);                                // R8 read at slot 0
    chk(irq_out == 8'hA5, "R8", 64'(irq_out), 64'hA5);
    step(1, 0, 64'h70, 64'h0);                                // R5 back-to-back
    step(1, 0, 64'h30, 64'h0);
    step(0, 0, 64'h0, 64'h0);
    step(1, 1, 64'h0000_0000_0000_0000, 64'h00);              // R2 clear
    step(1, 1, 64'h8000_0000_0000_000F, 64'h5C);              // R4
    chk(irq_out == 8'h5C, "R4", 64'(irq_out), 64'h5C);

    // constrained random
    for (int i = 0; i < 400; i++) begin
      logic [63:0] a;
      logic v, w;
      a = {$urandom, $urandom};
      if ($urandom_range(0, 2) == 0) a[6:4] = 3'b000;
      v = ($urandom_range(0, 4) != 0);
      w = $urandom_range(0, 1) == 1;
      step(v, w, a, {$urandom, $urandom});
    end

    step(0, 0, 64'h0, 64'h0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule